// File: doc/BRIEF.md
# PCIe Configuration Access Bridge

This block turns one configuration-space request (bus, device, function, register offset, access size, direction and write data) into 32-bit word accesses on a simple memory-mapped port. A request whose bus number belongs to one of the root ports is sent to that port's own register window. Any other bus number is mapped into a flat configuration aperture. In that aperture, the register offset also picks between a standard region and an extended region.

Reads return the addressed bytes shifted down to bit 0. A 4-byte write is passed straight through. A 1-byte or 2-byte write is carried out in hardware as read, merge and write back. Every request finishes with a one-cycle done pulse that carries a status code and the read data. Only one request is handled at a time. A software layer that walks the configuration space of a hierarchy uses this block for each access.

Top module: `cfg_access_bridge`

## Requirements
- R1: For a bus that matches no active root port, the word address is CFG_BASE + bus·2^16 + device·2^11 + function·2^8 + (offset with bits [1:0] cleared). To this is added 0x4000 when the offset is below 256, and 0x104000 when the offset is 256 or above.
- R2: For a bus that matches a root port with device 0 and function 0, the word address is RP_BASE + port_index·RP_STRIDE + (offset with bits [1:0] cleared).
- R3: On a root-port bus, a non-zero device or function finishes with status 1 (device not found) and read data 0xFFFFFFFF. It makes no bus access, so a write of this kind is dropped.
- R4: A 1-byte read returns bits [8·(offset mod 4) +: 8] of the word. A 2-byte read returns 16 bits at the same shift. Any other read size returns the whole word. The upper bits are zero.
- R5: A 4-byte write makes exactly one bus write, carrying the request data unchanged.
- R6: A 1-byte or 2-byte write makes one bus read and then one bus write to the same address. The written word is the old word with the target lanes replaced by the low 8 or 16 bits of the data, shifted by 8·(offset mod 4).
- R7: Status 2 (bad register) is returned, with data 0xFFFFFFFF and no bus access, for two cases: a write whose size is not 1, 2 or 4, and a 2-byte access of either direction with offset mod 4 equal to 3. Status 0 means success.
- R8: Root ports are searched from the highest index down, so the highest matching index wins. A port whose enable bit is 0 never matches.
- R9: busy rises on the cycle after a request is accepted and stays high until the cycle after the one-cycle done pulse. req_valid is ignored while busy is high.
- R10: mem_req stays asserted, with a stable address, write flag and write data, until mem_ack is seen. mem_req is never asserted while the block is idle.
- R11: After reset, busy, done and mem_req are low, and rsp_status and rsp_rdata are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_bus | input | 8 | Bus number |
| req_dev | input | 5 | Device number |
| req_func | input | 3 | Function number |
| req_reg | input | 12 | Register byte offset |
| req_size | input | 3 | Access size in bytes |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data, right-aligned |
| rp_en | input | 2 | Per-port enable (0 marks an unused port) |
| rp_bus | input | 16 | Root bus numbers, port i at [8i +: 8] |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| rsp_status | output | 2 | 0 ok, 1 device not found, 2 bad register |
| rsp_rdata | output | 32 | Read result |
| mem_req | output | 1 | Downstream access request |
| mem_we | output | 1 | Downstream write flag |
| mem_addr | output | 32 | Downstream word address |
| mem_wdata | output | 32 | Downstream write data |
| mem_ack | input | 1 | Downstream completion |
| mem_rdata | input | 32 | Downstream read data, valid with mem_ack |

## Verification
A wrong decode state shows up at the port within the same transaction. It appears as a wrong mem_addr on the first access, a wrong count of accesses (0, 1 or 2), or a wrong status at the done pulse a few cycles later. A corrupted merge is visible only in the word written back on the second access, so the bench keeps a memory model and compares every stored word against a merge computed on its own. Sequencer faults such as a lost done pulse, a stuck busy, or a second request taken while busy appear as extra accesses or done pulses within a few cycles after completion.

// File: rtl/cfgb_pkg.sv
// Package: shared widths and the completion status type of the bridge.
package cfgb_pkg;
    localparam int BUS_W = 8;
    localparam int DEV_W = 5;
    localparam int FN_W  = 3;
    localparam int REG_W = 12;
    localparam int SZ_W  = 3;
    localparam int DW    = 32;
    localparam int AW    = 32;

    typedef enum logic [1:0] {
        ST_OK     = 2'd0,
        ST_NODEV  = 2'd1,
        ST_BADREG = 2'd2
    } cfg_status_e;

    typedef struct packed {
        logic [BUS_W-1:0] bus;
        logic [DEV_W-1:0] dev;
        logic [FN_W-1:0]  fn;
        logic [REG_W-1:0] rg;
        logic [SZ_W-1:0]  sz;
        logic             wr;
        logic [DW-1:0]    wdata;
    } cfg_req_t;
endpackage

// File: rtl/cfgb_port_match.sv
// Root-port lookup. It compares the bus number against every enabled
// root port and reports the highest matching index.
// Assumes: rp_bus packs port i at [i*BUS_W +: BUS_W].
module cfgb_port_match import cfgb_pkg::*; #(
    parameter int NPORT = 2,
    localparam int IDX_W = (NPORT > 1) ? $clog2(NPORT) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [BUS_W-1:0]       bus,
    input  logic [NPORT-1:0]       rp_en,
    input  logic [NPORT*BUS_W-1:0] rp_bus,
    output logic                   hit,
    output logic [IDX_W-1:0]       idx
);
    logic [NPORT-1:0] eq;

    // Per-port equality, gated by the port enable.
    for (genvar g = 0; g < NPORT; g++) begin : g_cmp
        assign eq[g] = rp_en[g] && (rp_bus[g*BUS_W +: BUS_W] == bus);
    end

    // Priority pick: search from the highest index downwards.
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = NPORT - 1; i >= 0; i--) begin
            if (eq[i] && !hit) begin
                hit = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end

    assert_highest_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> ((eq >> idx) == NPORT'(1)));
    assert_miss_means_none_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (eq == '0));
endmodule

// File: rtl/cfgb_addr_gen.sv
// Address former. It builds the word address either in a root port's
// window or in the flat configuration aperture (standard or extended region).
// Assumes: bases are word aligned.
module cfgb_addr_gen import cfgb_pkg::*; #(
    parameter int           NPORT         = 2,
    parameter logic [AW-1:0] CFG_BASE     = 32'h8000_0000,
    parameter logic [AW-1:0] RP_BASE      = 32'h8000_0000,
    parameter logic [AW-1:0] RP_STRIDE    = 32'h0000_1000,
    parameter logic [AW-1:0] STD_OFF      = 32'h0000_4000,
    parameter logic [AW-1:0] EXT_OFF      = 32'h0010_4000,
    parameter int           EXT_REG_START = 256,
    localparam int IDX_W = (NPORT > 1) ? $clog2(NPORT) : 1
) (
    input  logic [BUS_W-1:0] bus,
    input  logic [DEV_W-1:0] dev,
    input  logic [FN_W-1:0]  fn,
    input  logic [REG_W-1:0] rg,
    input  logic             port_hit,
    input  logic [IDX_W-1:0] port_idx,
    output logic [AW-1:0]    addr
);
    logic [AW-1:0] word_off;
    logic [AW-1:0] region_off;
    logic [AW-1:0] flat_addr;
    logic [AW-1:0] port_addr;

    // Word-aligned register offset and region select.
    always_comb begin
        word_off   = AW'({rg[REG_W-1:2], 2'b00});
        region_off = (int'(rg) < EXT_REG_START) ? STD_OFF : EXT_OFF;
    end

    // Flat aperture and root-port window addresses, then the final pick.
    always_comb begin
        flat_addr = CFG_BASE + (AW'(bus) << 16) + (AW'(dev) << 11)
                  + (AW'(fn) << 8) + word_off + region_off;
        port_addr = RP_BASE + (AW'(port_idx) * RP_STRIDE) + word_off;
        addr      = port_hit ? port_addr : flat_addr;
    end
endmodule

// File: rtl/cfgb_lanes.sv
// Byte-lane unit. It extracts the addressed lanes of a read word and
// merges sub-word write data into a word for read-modify-write.
// Assumes: off is offset mod 4; misaligned 2-byte cases are filtered upstream.
module cfgb_lanes import cfgb_pkg::*; (
    input  logic [DW-1:0]   word,
    input  logic [1:0]      off,
    input  logic [SZ_W-1:0] sz,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   rd_ext,
    output logic [DW-1:0]   merged
);
    logic [4:0]    sh;
    logic [DW-1:0] lane_mask;

    // Lane mask and shift amount from size and offset.
    always_comb begin
        sh        = {off, 3'b000};
        lane_mask = (sz == SZ_W'(1)) ? DW'(32'h0000_00FF) : DW'(32'h0000_FFFF);
    end

    // Read extraction and write merge.
    always_comb begin
        if (sz == SZ_W'(1) || sz == SZ_W'(2))
            rd_ext = (word >> sh) & lane_mask;
        else
            rd_ext = word;
        merged = (word & ~(lane_mask << sh)) | ((wdata & lane_mask) << sh);
    end
endmodule

// File: rtl/cfgb_seq.sv
// Transaction sequencer. It accepts one request at a time, turns it into
// zero, one or two bus accesses and issues the completion.
// Assumes: mem_ack may come in any cycle where mem_req is high.
module cfgb_seq import cfgb_pkg::*; (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        rej,
    input  cfg_status_e rej_status,
    input  logic        is_write,
    input  logic        is_rmw,
    input  logic [DW-1:0] wdata_full,
    input  logic [DW-1:0] merged,
    input  logic [DW-1:0] rd_ext,
    input  logic        mem_ack,
    output logic        accept,
    output logic        busy,
    output logic        done,
    output logic [1:0]  rsp_status,
    output logic [DW-1:0] rsp_rdata,
    output logic        mem_req,
    output logic        mem_we,
    output logic [DW-1:0] mem_wdata
);
    typedef enum logic [2:0] {S_IDLE, S_DEC, S_RD, S_WR, S_DONE} seq_state_e;
    seq_state_e state;

    // Decoded control outputs.
    always_comb begin
        accept  = (state == S_IDLE) && req_valid;
        busy    = (state != S_IDLE);
        done    = (state == S_DONE);
        mem_req = (state == S_RD) || (state == S_WR);
        mem_we  = (state == S_WR);
    end

    // State register, write-data register and response registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            rsp_status <= 2'd0;
            rsp_rdata  <= '0;
            mem_wdata  <= '0;
        end else begin
            case (state)
                S_IDLE: if (accept) state <= S_DEC;
                S_DEC: begin
                    if (rej) begin
                        rsp_status <= rej_status;
                        rsp_rdata  <= '1;
                        state      <= S_DONE;
                    end else if (is_write && !is_rmw) begin
                        mem_wdata <= wdata_full;
                        state     <= S_WR;
                    end else begin
                        state <= S_RD;
                    end
                end
                S_RD: if (mem_ack) begin
                    if (is_rmw) begin
                        mem_wdata <= merged;
                        state     <= S_WR;
                    end else begin
                        rsp_rdata  <= rd_ext;
                        rsp_status <= ST_OK;
                        state      <= S_DONE;
                    end
                end
                S_WR: if (mem_ack) begin
                    rsp_rdata  <= '0;
                    rsp_status <= ST_OK;
                    state      <= S_DONE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_busy_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy);
    assert_req_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_wdata)));
    assert_no_req_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);
    assert_reject_no_bus_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DEC && rej) |=> (!mem_req && done));
    assert_rmw_writes_back_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RD && mem_ack && is_rmw) |=> (mem_req && mem_we));
endmodule

// File: rtl/cfg_access_bridge.sv
// Top of the configuration access bridge. It captures one request,
// classifies it (root port or flat aperture, reject or access) and hands
// it to the sequencer.
// Assumes: the downstream port returns mem_rdata together with mem_ack.
module cfg_access_bridge import cfgb_pkg::*; #(
    parameter int           NPORT         = 2,
    parameter logic [AW-1:0] CFG_BASE     = 32'h8000_0000,
    parameter logic [AW-1:0] RP_BASE      = 32'h8000_0000,
    parameter logic [AW-1:0] RP_STRIDE    = 32'h0000_1000,
    parameter logic [AW-1:0] STD_OFF      = 32'h0000_4000,
    parameter logic [AW-1:0] EXT_OFF      = 32'h0010_4000,
    parameter int           EXT_REG_START = 256,
    localparam int IDX_W = (NPORT > 1) ? $clog2(NPORT) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic [BUS_W-1:0]       req_bus,
    input  logic [DEV_W-1:0]       req_dev,
    input  logic [FN_W-1:0]        req_func,
    input  logic [REG_W-1:0]       req_reg,
    input  logic [SZ_W-1:0]        req_size,
    input  logic                   req_write,
    input  logic [DW-1:0]          req_wdata,
    input  logic [NPORT-1:0]       rp_en,
    input  logic [NPORT*BUS_W-1:0] rp_bus,
    output logic                   busy,
    output logic                   done,
    output logic [1:0]             rsp_status,
    output logic [DW-1:0]          rsp_rdata,
    output logic                   mem_req,
    output logic                   mem_we,
    output logic [AW-1:0]          mem_addr,
    output logic [DW-1:0]          mem_wdata,
    input  logic                   mem_ack,
    input  logic [DW-1:0]          mem_rdata
);
    cfg_req_t    req_q;
    logic        accept;
    logic        port_hit;
    logic [IDX_W-1:0] port_idx;
    logic        size_ok_wr;
    logic        misalign;
    logic        rej;
    cfg_status_e rej_status;
    logic        is_rmw;
    logic [DW-1:0] rd_ext;
    logic [DW-1:0] merged;

    // Request capture on acceptance; held for the whole transaction.
    always_ff @(posedge clk) begin
        if (!rst_n)
            req_q <= '0;
        else if (accept)
            req_q <= '{bus: req_bus, dev: req_dev, fn: req_func, rg: req_reg,
                       sz: req_size, wr: req_write, wdata: req_wdata};
    end

    cfgb_port_match #(.NPORT(NPORT)) u_match (
        .clk(clk), .rst_n(rst_n), .bus(req_q.bus), .rp_en(rp_en),
        .rp_bus(rp_bus), .hit(port_hit), .idx(port_idx)
    );

    cfgb_addr_gen #(
        .NPORT(NPORT), .CFG_BASE(CFG_BASE), .RP_BASE(RP_BASE),
        .RP_STRIDE(RP_STRIDE), .STD_OFF(STD_OFF), .EXT_OFF(EXT_OFF),
        .EXT_REG_START(EXT_REG_START)
    ) u_addr (
        .bus(req_q.bus), .dev(req_q.dev), .fn(req_q.fn), .rg(req_q.rg),
        .port_hit(port_hit), .port_idx(port_idx), .addr(mem_addr)
    );

    // Request classification: root-port device check first, then size rules.
    always_comb begin
        size_ok_wr = (req_q.sz == SZ_W'(1)) || (req_q.sz == SZ_W'(2))
                  || (req_q.sz == SZ_W'(4));
        misalign   = (req_q.sz == SZ_W'(2)) && (req_q.rg[1:0] == 2'b11);
        is_rmw     = req_q.wr && ((req_q.sz == SZ_W'(1)) || (req_q.sz == SZ_W'(2)));
        rej        = 1'b0;
        rej_status = ST_OK;
        if (port_hit && ((req_q.dev != '0) || (req_q.fn != '0))) begin
            rej        = 1'b1;
            rej_status = ST_NODEV;
        end else if ((req_q.wr && !size_ok_wr) || misalign) begin
            rej        = 1'b1;
            rej_status = ST_BADREG;
        end
    end

    cfgb_lanes u_lanes (
        .word(mem_rdata), .off(req_q.rg[1:0]), .sz(req_q.sz),
        .wdata(req_q.wdata), .rd_ext(rd_ext), .merged(merged)
    );

    cfgb_seq u_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .rej(rej),
        .rej_status(rej_status), .is_write(req_q.wr), .is_rmw(is_rmw),
        .wdata_full(req_q.wdata), .merged(merged), .rd_ext(rd_ext),
        .mem_ack(mem_ack), .accept(accept), .busy(busy), .done(done),
        .rsp_status(rsp_status), .rsp_rdata(rsp_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_wdata(mem_wdata)
    );

    assert_addr_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> $stable(mem_addr));
    assert_done_status_known_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (rsp_status != 2'd3));
endmodule

// File: tb/tb_cfg_access_bridge.sv
`timescale 1ns/1ps
module tb_cfg_access_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [7:0]  req_bus = '0;
    logic [4:0]  req_dev = '0;
    logic [2:0]  req_func = '0;
    logic [11:0] req_reg = '0;
    logic [2:0]  req_size = '0;
    logic        req_write = 1'b0;
    logic [31:0] req_wdata = '0;
    logic [1:0]  rp_en = 2'b11;
    logic [15:0] rp_bus = {8'd4, 8'd0};
    logic        busy, done, mem_req, mem_we;
    logic [1:0]  rsp_status;
    logic [31:0] rsp_rdata, mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    int n_tests = 0;
    int n_fail  = 0;
    int acc_cnt = 0;
    int done_cnt = 0;
    logic [31:0] first_addr = '0;
    logic [31:0] mem_store [logic [31:0]];

    always #2.5 clk = ~clk;

    cfg_access_bridge dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_bus(req_bus),
        .req_dev(req_dev), .req_func(req_func), .req_reg(req_reg),
        .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
        .rp_en(rp_en), .rp_bus(rp_bus), .busy(busy), .done(done),
        .rsp_status(rsp_status), .rsp_rdata(rsp_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    function automatic logic [31:0] peek(input logic [31:0] a);
        if (mem_store.exists(a)) return mem_store[a];
        return {a[15:0], ~a[15:0]};
    endfunction

    // Downstream memory model: ack one cycle after request, write on ack.
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
        end else begin
            if (mem_req && !mem_ack) begin
                mem_ack   <= 1'b1;
                mem_rdata <= peek(mem_addr);
            end else begin
                mem_ack <= 1'b0;
            end
            if (mem_req && mem_ack) begin
                if (acc_cnt == 0) first_addr = mem_addr;
                acc_cnt = acc_cnt + 1;
                if (mem_we) mem_store[mem_addr] = mem_wdata;
            end
            if (done) done_cnt = done_cnt + 1;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic run_req(input logic [7:0] b, input logic [4:0] d, input logic [2:0] f,
                           input logic [11:0] r, input logic [2:0] s, input logic w,
                           input logic [31:0] wd);
        int waitc;
        @(negedge clk);
        acc_cnt = 0; done_cnt = 0; first_addr = '0;
        req_bus = b; req_dev = d; req_func = f; req_reg = r;
        req_size = s; req_write = w; req_wdata = wd; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        waitc = 0;
        while (!done && waitc < 100) begin
            @(negedge clk);
            waitc++;
        end
    endtask

    function automatic logic [31:0] extract(input logic [31:0] wv, input logic [1:0] o,
                                            input logic [2:0] s);
        if (s == 3'd1) return (wv >> (8*o)) & 32'hFF;
        if (s == 3'd2) return (wv >> (8*o)) & 32'hFFFF;
        return wv;
    endfunction

    function automatic logic [31:0] merge(input logic [31:0] wv, input logic [1:0] o,
                                          input logic [2:0] s, input logic [31:0] wd);
        logic [31:0] m;
        m = (s == 3'd1) ? 32'hFF : 32'hFFFF;
        return (wv & ~(m << (8*o))) | ((wd & m) << (8*o));
    endfunction

    typedef struct packed {
        logic [7:0]  bus; logic [4:0] dev; logic [2:0] fn; logic [11:0] rg;
        logic [2:0]  sz;  logic wr; logic [31:0] wd; logic [1:0] st; logic [31:0] ad;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{8'd2, 5'd3, 3'd1, 12'h010, 3'd4, 1'b0, 32'h0,        2'd0, 32'h8002_5910}, // R1 std
        '{8'd5, 5'd0, 3'd0, 12'h104, 3'd4, 1'b0, 32'h0,        2'd0, 32'h8015_4104}, // R1 ext
        '{8'd0, 5'd0, 3'd0, 12'h03C, 3'd1, 1'b0, 32'h0,        2'd0, 32'h8000_003C}, // R2 R4
        '{8'd4, 5'd0, 3'd0, 12'h00E, 3'd2, 1'b0, 32'h0,        2'd0, 32'h8000_100C}, // R2 R4
        '{8'd4, 5'd1, 3'd0, 12'h000, 3'd4, 1'b0, 32'h0,        2'd1, 32'h0},         // R3 read
        '{8'd0, 5'd0, 3'd2, 12'h010, 3'd4, 1'b1, 32'h1111_2222, 2'd1, 32'h0},        // R3 write
        '{8'd1, 5'd2, 3'd0, 12'h041, 3'd1, 1'b1, 32'h0000_775A, 2'd0, 32'h8001_5040}, // R6 byte
        '{8'd1, 5'd0, 3'd0, 12'h042, 3'd2, 1'b1, 32'h00AA_BEEF, 2'd0, 32'h8001_4040}, // R6 half
        '{8'd3, 5'd0, 3'd0, 12'h200, 3'd4, 1'b1, 32'h1234_5678, 2'd0, 32'h8013_4200}, // R5
        '{8'd3, 5'd0, 3'd0, 12'h020, 3'd3, 1'b1, 32'h5555_5555, 2'd2, 32'h0},        // R7 size
        '{8'd3, 5'd0, 3'd0, 12'h013, 3'd2, 1'b0, 32'h0,        2'd2, 32'h0},         // R7 align
        '{8'd7, 5'd31, 3'd7, 12'h0FF, 3'd1, 1'b0, 32'h0,       2'd0, 32'h8008_3FFC}  // R1 R4 top
    };

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        logic [31:0] old_w;
        int exp_acc;
        repeat (3) @(negedge clk);
        // R11: reset state
        check(!busy && !done && !mem_req, "R11 idle outputs", {busy, done, mem_req}, 0);
        check(rsp_status == 0 && rsp_rdata == 0, "R11 response regs", rsp_rdata, 0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            old_w   = peek(VEC[i].ad);
            exp_acc = (VEC[i].st != 0) ? 0 : (!VEC[i].wr ? 1 : (VEC[i].sz == 3'd4 ? 1 : 2));
            run_req(VEC[i].bus, VEC[i].dev, VEC[i].fn, VEC[i].rg, VEC[i].sz, VEC[i].wr, VEC[i].wd);
            check(done && rsp_status == VEC[i].st, $sformatf("R3/R7 vec%0d status", i),
                  32'(rsp_status), 32'(VEC[i].st));
            check(acc_cnt == exp_acc, $sformatf("R3/R5/R6/R7 vec%0d access count", i),
                  acc_cnt, exp_acc);
            if (exp_acc > 0)
                check(first_addr == VEC[i].ad, $sformatf("R1/R2 vec%0d address", i),
                      first_addr, VEC[i].ad);
            if (VEC[i].st != 0)
                check(rsp_rdata == 32'hFFFF_FFFF, $sformatf("R3/R7 vec%0d ones", i),
                      rsp_rdata, 32'hFFFF_FFFF);
            else if (!VEC[i].wr)
                check(rsp_rdata == extract(old_w, VEC[i].rg[1:0], VEC[i].sz),
                      $sformatf("R4 vec%0d read data", i), rsp_rdata,
                      extract(old_w, VEC[i].rg[1:0], VEC[i].sz));
            else if (VEC[i].sz == 3'd4)
                check(peek(VEC[i].ad) == VEC[i].wd, $sformatf("R5 vec%0d stored", i),
                      peek(VEC[i].ad), VEC[i].wd);
            else
                check(peek(VEC[i].ad) == merge(old_w, VEC[i].rg[1:0], VEC[i].sz, VEC[i].wd),
                      $sformatf("R6 vec%0d merged", i), peek(VEC[i].ad),
                      merge(old_w, VEC[i].rg[1:0], VEC[i].sz, VEC[i].wd));
        end

        // R8: both ports claim bus 6, port 1 must win
        rp_bus = {8'd6, 8'd6};
        run_req(8'd6, 5'd0, 3'd0, 12'h008, 3'd4, 1'b0, 0);
        check(first_addr == 32'h8000_1008, "R8 highest port wins", first_addr, 32'h8000_1008);

        // R8: disabled port 1 does not match, so bus 4 dev 1 goes to the flat aperture
        rp_en = 2'b01; rp_bus = {8'd4, 8'd0};
        run_req(8'd4, 5'd1, 3'd0, 12'h000, 3'd4, 1'b0, 0);
        check(rsp_status == 0, "R8 disabled port status", 32'(rsp_status), 0);
        check(first_addr == 32'h8004_4800, "R8 disabled port address", first_addr, 32'h8004_4800);
        rp_en = 2'b11;

        // R4: read of size 0 returns the whole word
        old_w = peek(32'h8002_4010);
        run_req(8'd2, 5'd0, 3'd0, 12'h013, 3'd0, 1'b0, 0);
        check(rsp_rdata == old_w, "R4 odd size full word", rsp_rdata, old_w);

        // R7: misaligned 2-byte write is rejected without access
        run_req(8'd2, 5'd0, 3'd0, 12'h00F, 3'd2, 1'b1, 32'hFFFF);
        check(rsp_status == 2 && acc_cnt == 0, "R7 misaligned write", acc_cnt, 0);

        // R6 R2: byte write inside a root port window
        old_w = peek(32'h8000_1020);
        run_req(8'd4, 5'd0, 3'd0, 12'h021, 3'd1, 1'b1, 32'h0000_00C3);
        check(acc_cnt == 2, "R6 root port rmw accesses", acc_cnt, 2);
        check(peek(32'h8000_1020) == merge(old_w, 2'd1, 3'd1, 32'hC3), "R6 root port merged",
              peek(32'h8000_1020), merge(old_w, 2'd1, 3'd1, 32'hC3));

        // R9: busy behaviour and request ignored while busy
        @(negedge clk);
        acc_cnt = 0; done_cnt = 0; first_addr = '0;
        req_bus = 8'd2; req_dev = 0; req_func = 0; req_reg = 12'h010;
        req_size = 3'd4; req_write = 1'b0; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(busy == 1'b1, "R9 busy after accept", 32'(busy), 1);
        @(negedge clk);
        req_bus = 8'd9; req_reg = 12'h080; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (10) @(negedge clk);
        check(done_cnt == 1, "R9 single done", done_cnt, 1);
        check(acc_cnt == 1 && first_addr == 32'h8002_4010, "R9 busy request ignored",
              first_addr, 32'h8002_4010);
        check(!busy && !mem_req, "R9 R10 idle after done", {busy, mem_req}, 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule